// File: doc/BRIEF.md
# Scanline Display Capture Blender

This block copies one display line into a bank of video memory each time a line starts. It writes the line one 16-bit pixel per clock. A pixel holds red in bits 4:0, green in bits 9:5, blue in bits 14:10 and an alpha bit in bit 15.

Each line draws its pixels from one of three places. The first is source A, which is either the composed screen or the 3D renderer's line. The second is source B, which is either a line read back from video memory or the display FIFO. The third is a weighted mix of A and B. A 28-bit control word picks the source and sets the mix weights. It also sets the line width (128 or 256 pixels), the number of lines to capture, and the source and destination banks. A per-bank flag says whether each bank is currently mapped for capture use. If the destination bank is not mapped, the whole line is dropped. If the source bank is not mapped, memory reads return zero.

The surrounding pipeline raises `line_start` with the line index at the beginning of each scanline. It presents pixel data for the index shown on `pix_x` during the same cycle. The block then drives a plain write port (valid, byte address, data) toward video memory.

Top module: `line_capture_blender`

## Requirements
- R1: Control word fields: bit 0 enable, bits 2:1 source mode, bit 3 selects the 3D line for source A, bit 4 selects the display FIFO for source B, bits 9:5 weight A, bits 14:10 weight B, bit 15 wide line (256 pixels, else 128), bits 23:16 line count, bits 25:24 source bank, bits 27:26 destination bank. The control word is sampled only when `line_start` is accepted. A line start with enable clear produces no writes and no done pulse. A line start that arrives while a line is still being captured is ignored.
- R2: A line is captured only when its index is below the line-count field. Any other line produces no writes and no done pulse.
- R3: Source mode 0 writes the source A pixel unchanged, all 16 bits. Source A is the composed screen when bit 3 is 0 and the 3D line when bit 3 is 1.
- R4: Source mode 1 with bit 4 clear writes the memory pixel read at byte address source_bank×32768 + line×512 + 2×x. If the source bank flag is clear, it writes zero instead.
- R5: Source modes 2 and 3 write a mix. Each 5-bit channel is (A×weightA + B×weightB) >> 4, clamped to 31. Bit 15 of the written pixel is always 0.
- R6: In the mix, a composed-screen A pixel always counts as opaque. A 3D A pixel adds its term only when its bit 15 is set. The B term never looks at B's bit 15. A zero weight removes its own term.
- R7: A wide line writes 256 pixels and a narrow line writes 128. The destination byte address is dest_bank×32768 + line×stride + 2×x, where the stride is 512 for wide lines and 256 for narrow ones.
- R8: If the destination bank flag is clear when the line is accepted, the line makes no writes. It still ends with a done pulse.
- R9: When bit 4 selects the display FIFO, source mode 1 and the mix modes make no writes. The line still ends with a done pulse.
- R10: The writes of a line happen on consecutive clocks, in ascending x. `line_done` is a one-cycle pulse in the cycle right after the last write.
- R11: While reset is held and after it is released, `wr_valid` and `line_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Start-of-line strobe |
| line_idx | input | 8 | Index of the starting line |
| ctrl | input | 28 | Control word (layout in R1) |
| bank_mapped | input | 4 | Per-bank "mapped for capture" flags |
| a_screen_pix | input | 16 | Composed screen pixel at `pix_x` |
| a_3d_pix | input | 16 | 3D line pixel at `pix_x` |
| b_mem_pix | input | 16 | Memory word at `src_addr` |
| pix_x | output | 8 | Pixel index currently requested |
| src_addr | output | 18 | Byte address of the source memory read |
| wr_valid | output | 1 | Pixel write strobe |
| wr_addr | output | 18 | Byte address of the pixel write |
| wr_data | output | 16 | Pixel written |
| line_done | output | 1 | End-of-line pulse |

## Verification
The assertions assume three things about the inputs while a line is running. The bank flags and the control word stay stable. The three pixel inputs respond combinationally to `pix_x` and `src_addr`, as a zero-latency read would. Line starts are at least one full line apart unless a start is deliberately sent early to test that it is ignored. The bench sets the control word and the flags one cycle before each strobe and holds them until the done pulse. It generates the pixel inputs from fixed functions of the requested index and address. The test patterns set bit 15 to both values on both sources, so the opacity rules have an effect in every mix test.

// File: rtl/scap_pkg.sv
package scap_pkg;

    localparam int CHAN_W = 5;
    localparam int NCHAN  = 3;
    localparam int PIX_W  = CHAN_W * NCHAN + 1;
    localparam int COEF_W = 5;
    localparam int LINE_W = 8;
    localparam int BANK_W = 2;
    localparam int NBANK  = 1 << BANK_W;

    // Control word, LSB at the bottom of the list
    typedef struct packed {
        logic [BANK_W-1:0] dst_bank;
        logic [BANK_W-1:0] src_bank;
        logic [LINE_W-1:0] height;
        logic              wide;
        logic [COEF_W-1:0] wt_b;
        logic [COEF_W-1:0] wt_a;
        logic              b_is_fifo;
        logic              a_is_3d;
        logic [1:0]        mode;
        logic              enable;
    } cap_ctrl_t;

    localparam int CTRL_W = $bits(cap_ctrl_t);

    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_RUN   = 2'd1,
        CAP_FLUSH = 2'd2
    } cap_state_t;

    localparam logic [1:0] MODE_A = 2'd0;
    localparam logic [1:0] MODE_B = 2'd1;

endpackage

// File: rtl/scap_blend_lane.sv
module scap_blend_lane
    import scap_pkg::*;
#(
    parameter int FRAC = 4
) (
    input  logic [CHAN_W-1:0] a_ch,
    input  logic [CHAN_W-1:0] b_ch,
    input  logic [COEF_W-1:0] wt_a,
    input  logic [COEF_W-1:0] wt_b,
    input  logic              a_opaque,
    output logic [CHAN_W-1:0] y
);
    localparam int PROD_W = CHAN_W + COEF_W;
    localparam int SUM_W  = PROD_W + 1;
    localparam logic [SUM_W-1:0] CH_MAX = SUM_W'((1 << CHAN_W) - 1);

    logic [PROD_W-1:0] term_a;
    logic [PROD_W-1:0] term_b;
    logic [SUM_W-1:0]  sum;
    logic [SUM_W-1:0]  scaled;

    always_comb begin
        term_a = '0;
        if (a_opaque && (wt_a != '0)) begin
            term_a = PROD_W'(a_ch) * PROD_W'(wt_a);
        end
        term_b = PROD_W'(b_ch) * PROD_W'(wt_b);
        sum    = SUM_W'(term_a) + SUM_W'(term_b);
        scaled = sum >> FRAC;
        y      = (scaled > CH_MAX) ? {CHAN_W{1'b1}} : scaled[CHAN_W-1:0];
    end

    // R5: with both weights zero the channel must come out black
    always_comb begin
        if ((wt_a == '0) && (wt_b == '0)) begin
            a_r5_zero_weights: assert (y == '0);
        end
    end

    // R6: a masked A term with no B weight leaves nothing
    always_comb begin
        if (!a_opaque && (wt_b == '0)) begin
            a_r6_masked_a: assert (y == '0);
        end
    end

endmodule

// File: rtl/scap_pixel_path.sv
module scap_pixel_path
    import scap_pkg::*;
(
    input  logic [1:0]        mode,
    input  logic              a_is_3d,
    input  logic [COEF_W-1:0] wt_a,
    input  logic [COEF_W-1:0] wt_b,
    input  logic              src_ok,
    input  logic [PIX_W-1:0]  scr_pix,
    input  logic [PIX_W-1:0]  td_pix,
    input  logic [PIX_W-1:0]  mem_pix,
    output logic [PIX_W-1:0]  pix
);
    logic [PIX_W-1:0] a_pix;
    logic [PIX_W-1:0] b_pix;
    logic [PIX_W-1:0] mix;
    logic             a_opaque;

    always_comb begin
        a_pix    = a_is_3d ? td_pix : scr_pix;
        b_pix    = src_ok ? mem_pix : '0;
        a_opaque = !a_is_3d || a_pix[PIX_W-1];
    end

    for (genvar c = 0; c < NCHAN; c++) begin : g_lane
        scap_blend_lane #(
            .FRAC (4)
        ) u_lane (
            .a_ch     (a_pix[c*CHAN_W +: CHAN_W]),
            .b_ch     (b_pix[c*CHAN_W +: CHAN_W]),
            .wt_a     (wt_a),
            .wt_b     (wt_b),
            .a_opaque (a_opaque),
            .y        (mix[c*CHAN_W +: CHAN_W])
        );
    end

    assign mix[PIX_W-1] = 1'b0;

    always_comb begin
        if (mode == MODE_A) begin
            pix = a_pix;
        end else if (mode == MODE_B) begin
            pix = b_pix;
        end else begin
            pix = mix;
        end
    end

endmodule

// File: rtl/scap_addr_gen.sv
module scap_addr_gen
    import scap_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int BANK_BYTES    = 32768,
    parameter int SRC_STRIDE    = 512,
    parameter int NARROW_STRIDE = 256,
    parameter int WIDE_STRIDE   = 512,
    parameter int X_W           = 8
) (
    input  logic [BANK_W-1:0] src_bank,
    input  logic [BANK_W-1:0] dst_bank,
    input  logic [LINE_W-1:0] line,
    input  logic [X_W-1:0]    x,
    input  logic              wide,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);
    localparam int PIX_BYTES = PIX_W / 8;

    logic [ADDR_W-1:0] dst_stride;
    logic [ADDR_W-1:0] x_ofs;

    always_comb begin
        dst_stride = wide ? ADDR_W'(WIDE_STRIDE) : ADDR_W'(NARROW_STRIDE);
        x_ofs      = ADDR_W'(x) * ADDR_W'(PIX_BYTES);
        src_addr   = ADDR_W'(src_bank) * ADDR_W'(BANK_BYTES)
                   + ADDR_W'(line) * ADDR_W'(SRC_STRIDE) + x_ofs;
        dst_addr   = ADDR_W'(dst_bank) * ADDR_W'(BANK_BYTES)
                   + ADDR_W'(line) * dst_stride + x_ofs;
    end

endmodule

// File: rtl/line_capture_blender.sv
module line_capture_blender
    import scap_pkg::*;
#(
    parameter int  WIDE_PIX   = 256,
    parameter int  NARROW_PIX = 128,
    parameter int  BANK_BYTES = 32768,
    parameter int  SRC_STRIDE = 512,
    parameter int  ADDR_W     = 18,
    localparam int X_W        = $clog2(WIDE_PIX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_idx,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [NBANK-1:0]  bank_mapped,
    input  logic [PIX_W-1:0]  a_screen_pix,
    input  logic [PIX_W-1:0]  a_3d_pix,
    input  logic [PIX_W-1:0]  b_mem_pix,
    output logic [X_W-1:0]    pix_x,
    output logic [ADDR_W-1:0] src_addr,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [PIX_W-1:0]  wr_data,
    output logic              line_done
);
    localparam int PIX_BYTES     = PIX_W / 8;
    localparam int NARROW_STRIDE = NARROW_PIX * PIX_BYTES;
    localparam int WIDE_STRIDE   = WIDE_PIX * PIX_BYTES;
    localparam logic [X_W-1:0] LAST_WIDE   = X_W'(WIDE_PIX - 1);
    localparam logic [X_W-1:0] LAST_NARROW = X_W'(NARROW_PIX - 1);

    typedef struct packed {
        cap_state_t        st;
        cap_ctrl_t         cfg;
        logic [LINE_W-1:0] line;
        logic [X_W-1:0]    x;
        logic              dst_ok;
        logic              src_ok;
        logic              wr_v;
        logic [ADDR_W-1:0] wr_a;
        logic [PIX_W-1:0]  wr_d;
        logic              done;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    cap_ctrl_t         cfg_in;
    logic [ADDR_W-1:0] dst_addr;
    logic [PIX_W-1:0]  pix;
    logic [X_W-1:0]    last_x;
    logic              fifo_blocked;

    assign cfg_in = cap_ctrl_t'(ctrl);

    scap_addr_gen #(
        .ADDR_W        (ADDR_W),
        .BANK_BYTES    (BANK_BYTES),
        .SRC_STRIDE    (SRC_STRIDE),
        .NARROW_STRIDE (NARROW_STRIDE),
        .WIDE_STRIDE   (WIDE_STRIDE),
        .X_W           (X_W)
    ) u_addr (
        .src_bank (ctx_q.cfg.src_bank),
        .dst_bank (ctx_q.cfg.dst_bank),
        .line     (ctx_q.line),
        .x        (ctx_q.x),
        .wide     (ctx_q.cfg.wide),
        .src_addr (src_addr),
        .dst_addr (dst_addr)
    );

    scap_pixel_path u_pix (
        .mode    (ctx_q.cfg.mode),
        .a_is_3d (ctx_q.cfg.a_is_3d),
        .wt_a    (ctx_q.cfg.wt_a),
        .wt_b    (ctx_q.cfg.wt_b),
        .src_ok  (ctx_q.src_ok),
        .scr_pix (a_screen_pix),
        .td_pix  (a_3d_pix),
        .mem_pix (b_mem_pix),
        .pix     (pix)
    );

    always_comb begin
        ctx_d        = ctx_q;
        ctx_d.wr_v   = 1'b0;
        ctx_d.done   = 1'b0;
        last_x       = ctx_q.cfg.wide ? LAST_WIDE : LAST_NARROW;
        fifo_blocked = (cfg_in.mode != MODE_A) && cfg_in.b_is_fifo;
        case (ctx_q.st)
            CAP_IDLE: begin
                if (line_start && cfg_in.enable && (line_idx < cfg_in.height)) begin
                    ctx_d.st     = CAP_RUN;
                    ctx_d.cfg    = cfg_in;
                    ctx_d.line   = line_idx;
                    ctx_d.x      = '0;
                    ctx_d.dst_ok = bank_mapped[cfg_in.dst_bank] && !fifo_blocked;
                    ctx_d.src_ok = bank_mapped[cfg_in.src_bank];
                end
            end
            CAP_RUN: begin
                ctx_d.wr_v = ctx_q.dst_ok;
                ctx_d.wr_a = dst_addr;
                ctx_d.wr_d = pix;
                if (ctx_q.x == last_x) begin
                    ctx_d.st = CAP_FLUSH;
                end else begin
                    ctx_d.x = ctx_q.x + 1'b1;
                end
            end
            CAP_FLUSH: begin
                ctx_d.done = 1'b1;
                ctx_d.st   = CAP_IDLE;
            end
            default: ctx_d.st = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign pix_x     = ctx_q.x;
    assign wr_valid  = ctx_q.wr_v;
    assign wr_addr   = ctx_q.wr_a;
    assign wr_data   = ctx_q.wr_d;
    assign line_done = ctx_q.done;

    // R10: the done pulse never coincides with a write
    a_r10_done_after_writes: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> !wr_valid);

    // R10: back-to-back writes step one pixel forward
    a_r10_step_two_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && $past(wr_valid)) |-> (wr_addr == $past(wr_addr) + ADDR_W'(PIX_BYTES)));

    // R2: only lines under the configured count write
    a_r2_line_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (ctx_q.line < ctx_q.cfg.height));

    // R1: only enabled lines write
    a_r1_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ctx_q.cfg.enable);

    // R5: mixed pixels leave the alpha bit clear
    a_r5_alpha_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && ctx_q.cfg.mode[1]) |-> !wr_data[PIX_W-1]);

    // R9: a FIFO-fed B source never reaches memory
    a_r9_fifo_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && (ctx_q.cfg.mode != MODE_A)) |-> !ctx_q.cfg.b_is_fifo);

    // R8: writes land only in a bank flagged as mapped
    a_r8_dest_mapped: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> bank_mapped[ctx_q.cfg.dst_bank]);

endmodule

// File: tb/line_capture_blender_tb.sv
`timescale 1ns/1ps
module line_capture_blender_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        line_start;
    logic [7:0]  line_idx;
    logic [27:0] ctrl;
    logic [3:0]  bank_mapped;
    logic [15:0] a_screen_pix, a_3d_pix, b_mem_pix;
    logic [7:0]  pix_x;
    logic [17:0] src_addr;
    logic        wr_valid;
    logic [17:0] wr_addr;
    logic [15:0] wr_data;
    logic        line_done;

    always #10 clk = ~clk;

    int    n_chk = 0, n_bad = 0;
    int    got_w, got_done, exp_w;
    logic  prev_wv;
    logic [27:0] cfg;
    int    cfg_line;
    logic [3:0] cfg_map;
    string cur_req;

    line_capture_blender u_dut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_idx(line_idx),
        .ctrl(ctrl), .bank_mapped(bank_mapped), .a_screen_pix(a_screen_pix),
        .a_3d_pix(a_3d_pix), .b_mem_pix(b_mem_pix), .pix_x(pix_x),
        .src_addr(src_addr), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .line_done(line_done)
    );

    function automatic logic [15:0] pat_scr(int x, int l);
        return 16'((x * 37 + l * 11) ^ (x << 9));
    endfunction
    function automatic logic [15:0] pat_3d(int x);
        return 16'((x * 613) ^ 16'h4c1d);
    endfunction
    function automatic logic [15:0] mem_word(int a);
        return 16'(((a * 40503) >> 3) ^ 16'ha5c3);
    endfunction

    assign a_screen_pix = pat_scr(int'(pix_x), cfg_line);
    assign a_3d_pix     = pat_3d(int'(pix_x));
    assign b_mem_pix    = mem_word(int'(src_addr));

    function automatic logic [27:0] mk(int en, int mode, int a3d, int bf, int wa, int wb,
                                       int wide, int h, int rb, int db);
        return 28'(en | (mode << 1) | (a3d << 3) | (bf << 4) | (wa << 5) | (wb << 10) |
                   (wide << 15) | (h << 16) | (rb << 24) | (db << 26));
    endfunction

    function automatic logic [15:0] exp_pix(int x);
        logic [15:0] a, b, r;
        int mode, wa, wb, rb, s;
        logic a3d;
        mode = int'(cfg[2:1]); a3d = cfg[3];
        wa = int'(cfg[9:5]); wb = int'(cfg[14:10]); rb = int'(cfg[25:24]);
        a = a3d ? pat_3d(x) : pat_scr(x, cfg_line);
        b = cfg_map[rb] ? mem_word(rb * 32768 + cfg_line * 512 + 2 * x) : 16'h0;
        if (mode == 0) return a;
        if (mode == 1) return b;
        r = 16'h0;
        for (int c = 0; c < 3; c++) begin
            s = 0;
            if (wa != 0 && (!a3d || a[15])) s += int'((a >> (5 * c)) & 16'h1f) * wa;
            if (wb != 0) s += int'((b >> (5 * c)) & 16'h1f) * wb;
            s = s >> 4;
            if (s > 31) s = 31;
            r = r | 16'(s << (5 * c));
        end
        return r;
    endfunction

    function automatic int exp_daddr(int x);
        int stride;
        stride = cfg[15] ? 512 : 256;
        return int'(cfg[27:26]) * 32768 + cfg_line * stride + 2 * x;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Write monitor: compares every write against the independent model
    always @(negedge clk) begin
        if (rst_n) begin
            if (line_done) begin
                got_done++;
                if (exp_w > 0)
                    chk(prev_wv && !wr_valid, "R10", "done placement", int'(prev_wv), 1);
            end
            if (wr_valid) begin
                if (got_w > 0)
                    chk(prev_wv, "R10", "write gap", int'(prev_wv), 1);
                chk(int'(wr_addr) == exp_daddr(got_w), "R7", "write address",
                    int'(wr_addr), exp_daddr(got_w));
                chk(wr_data == exp_pix(got_w), cur_req, "pixel data",
                    int'(wr_data), int'(exp_pix(got_w)));
                got_w++;
            end
            prev_wv = wr_valid;
        end
    end

    task automatic run_line(logic [27:0] c, int l, logic [3:0] m, string req,
                            int n_exp, int d_exp, int early);
        cfg = c; cfg_line = l; cfg_map = m; cur_req = req;
        got_w = 0; got_done = 0; exp_w = n_exp;
        @(negedge clk);
        ctrl = c; line_idx = 8'(l); bank_mapped = m; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        if (early > 0) begin
            repeat (early) @(negedge clk);
            line_idx = 8'(l + 1); line_start = 1'b1;
            @(negedge clk);
            line_start = 1'b0; line_idx = 8'(l);
        end
        for (int i = 0; i < 400 && got_done == 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(got_w == n_exp, req, "write count", got_w, n_exp);
        chk(got_done == d_exp, req, "done count", got_done, d_exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; line_start = 1'b0; line_idx = '0; ctrl = '0; bank_mapped = '0;
        cfg = '0; cfg_line = 0; cfg_map = '0; exp_w = 0; got_w = 0; got_done = 0;
        prev_wv = 1'b0; cur_req = "R11";
        repeat (3) @(negedge clk);
        chk(!wr_valid && !line_done, "R11", "outputs in reset", int'(wr_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!wr_valid && !line_done, "R11", "outputs after reset", int'(line_done), 0);
    endtask

    task automatic t_copy_screen();
        run_line(mk(1, 0, 0, 0, 0, 0, 1, 192, 0, 1), 5, 4'hf, "R3", 256, 1, 0);
    endtask
    task automatic t_copy_3d_narrow();
        run_line(mk(1, 0, 1, 0, 0, 0, 0, 192, 0, 2), 100, 4'hf, "R7", 128, 1, 0);
    endtask
    task automatic t_src_mem();
        run_line(mk(1, 1, 0, 0, 0, 0, 1, 192, 3, 0), 7, 4'hf, "R4", 256, 1, 0);
    endtask
    task automatic t_src_unmapped();
        run_line(mk(1, 1, 0, 0, 0, 0, 0, 192, 1, 0), 33, 4'b1101, "R4", 128, 1, 0);
    endtask
    task automatic t_mix_screen();
        run_line(mk(1, 2, 0, 0, 9, 7, 1, 192, 2, 3), 60, 4'hf, "R5", 256, 1, 0);
    endtask
    task automatic t_mix_3d();
        run_line(mk(1, 3, 1, 0, 16, 5, 0, 192, 0, 1), 12, 4'hf, "R6", 128, 1, 0);
    endtask
    task automatic t_mix_saturate();
        run_line(mk(1, 2, 0, 0, 31, 31, 1, 192, 1, 0), 90, 4'hf, "R5", 256, 1, 0);
    endtask
    task automatic t_mix_zero_weight();
        run_line(mk(1, 2, 0, 0, 0, 16, 0, 192, 3, 2), 44, 4'hf, "R6", 128, 1, 0);
    endtask
    task automatic t_dest_unmapped();
        run_line(mk(1, 0, 0, 0, 0, 0, 1, 192, 0, 2), 3, 4'b1011, "R8", 0, 1, 0);
    endtask
    task automatic t_fifo();
        run_line(mk(1, 1, 0, 1, 0, 0, 1, 192, 0, 1), 8, 4'hf, "R9", 0, 1, 0);
        run_line(mk(1, 2, 0, 1, 8, 8, 0, 192, 0, 1), 9, 4'hf, "R9", 0, 1, 0);
    endtask
    task automatic t_height();
        run_line(mk(1, 0, 0, 0, 0, 0, 0, 10, 0, 1), 10, 4'hf, "R2", 0, 0, 0);
        run_line(mk(1, 0, 0, 0, 0, 0, 0, 10, 0, 1), 9, 4'hf, "R2", 128, 1, 0);
    endtask
    task automatic t_disabled();
        run_line(mk(0, 0, 0, 0, 0, 0, 1, 192, 0, 1), 4, 4'hf, "R1", 0, 0, 0);
    endtask
    task automatic t_busy_restart();
        run_line(mk(1, 0, 1, 0, 0, 0, 0, 192, 0, 3), 20, 4'hf, "R1", 128, 1, 30);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_copy_screen();
        t_copy_3d_narrow();
        t_src_mem();
        t_src_unmapped();
        t_mix_screen();
        t_mix_3d();
        t_mix_saturate();
        t_mix_zero_weight();
        t_dest_unmapped();
        t_fifo();
        t_height();
        t_disabled();
        t_busy_restart();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule